// File: doc/BRIEF.md
# Hardware Task Context Switch Sequencer

This block carries out a full context switch between tasks whose state records sit in a word-addressed memory. It holds the live register set of the running task: sixteen dynamic words and six static words. It also holds the current-task selector and the base address of the current record. A request names a kind: jump, call or return. Jump and call requests also carry a 32-bit descriptor. The descriptor either gives the base of the incoming record directly, or it is a gate that holds a selector. For a gate, the block fetches the real descriptor from a descriptor table before it goes on.

A switch that is accepted first writes the sixteen dynamic words into the outgoing record, one word per cycle. A call then writes the outgoing selector into the back-link word of the incoming record. Next, the block reads all twenty-two state words of the incoming record into the live registers and updates the current-task registers. After a single check cycle it signals done. A return follows the back-link of the current record to find its target, and it saves the current state before loading. Requests that cannot be resolved raise a fault. A fault causes no memory write and no change to any live register.

Record layout, in word offsets from the record base:
- Offset 0 holds the back-link selector.
- Offsets 1 to 16 hold the dynamic words.
- Offsets 17 to 22 hold the static words.
- Bit 0 of offset 22 is the debug-trap bit.

The descriptor for a selector `s` sits at address `DESC_BASE + s`. A descriptor carries its type in bits [31:30], with 01 for a record and 10 for a gate. A record descriptor holds the record base in its low bits. A gate holds the selector in bits [15:0].

Top module: `task_switch_seq`

## Requirements
- R1: After reset the block is idle, `busy`, `done`, `fault` and `trap` are 0, `cur_task` is 0, and every live register word is 0.
- R2: A jump or call whose descriptor has type 01 saves the live dynamic words at offsets 1..16 of the current record. It then loads offsets 1..16 into `ctx_dyn` (word i at bits 32i+31:32i) and offsets 17..22 into `ctx_stat`. `cur_task` becomes `req_sel` and the current base becomes descriptor bits [AW-1:0].
- R3: A descriptor of type 10 is a gate. Its bits [15:0] give the selector. The block reads the word at `DESC_BASE + selector`, which must have type 01, and uses its low bits as the record base. `cur_task` becomes the gate's selector.
- R4: The static words (offsets 17..22) and the back-link word are never written, except for the back-link write that a call makes. Memory outside the outgoing record's dynamic words and that link word stays unchanged.
- R5: A call writes the outgoing selector, zero-extended, into offset 0 of the incoming record. A jump or a return leaves every back-link word as it was.
- R6: A return (kind 2) reads offset 0 of the current record and resolves that selector through the descriptor table. It saves the current dynamic words before it loads the target.
- R7: A one-cycle `fault` pulse ends the request with no memory write and no change to the live registers or `cur_task`. It is raised for request kind 3, for a descriptor type of 00 or 11, for a gate whose table entry is not type 01, and for a return that finds a back-link of zero.
- R8: `busy` is high from the cycle after acceptance until the request ends. `done` is high for exactly one cycle, after the load and a check cycle.
- R9: When bit 0 of loaded static word 5 is set, `trap` pulses high for one cycle, in the cycle after `done`. Otherwise it stays low.
- R10: A request presented while `busy` is high is ignored.
- R11: The save phase writes the sixteen dynamic words on sixteen consecutive cycles at ascending addresses. It is the only burst of writes apart from the single link write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req | input | 1 | Request strobe, sampled while idle |
| req_kind | input | 2 | 0 jump, 1 call, 2 return, 3 invalid |
| req_sel | input | 16 | Selector of the target when the descriptor is a record |
| req_desc | input | 32 | Target descriptor: type in [31:30] |
| mem_addr | output | AW | Memory word address |
| mem_we | output | 1 | Memory write enable |
| mem_wdata | output | 32 | Memory write data |
| mem_rdata | input | 32 | Memory read data, one cycle after the address |
| ctx_dyn | output | 512 | Live dynamic words |
| ctx_stat | output | 192 | Live static words |
| cur_task | output | 16 | Selector of the running task |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle completion pulse |
| fault | output | 1 | One-cycle rejection pulse |
| trap | output | 1 | One-cycle debug-trap pulse |

## Verification
Four properties are checked on every cycle:
- `done` never lasts more than one cycle.
- A fault leaves the live registers and `cur_task` untouched.
- Every write falls on the outgoing dynamic words or on the incoming link word, and save writes move to the next address each cycle.
- The selector changes only in the `done` cycle, and `trap` only follows `done`.

Other behaviour can only be shown by the bench's scenarios, which compare against a reference model of the whole memory:
- that the right record is loaded after gate and back-link resolution;
- that chained calls and returns unwind correctly;
- that switching to the current record reads back just-saved values;
- that requests made while busy are dropped.

// File: rtl/task_switch_seq.sv
module task_switch_seq #(
  parameter int AW = 16,
  parameter logic [AW-1:0] DESC_BASE = AW'('h800),
  localparam int NDYN = 16,
  localparam int NSTAT = 6
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  req,
  input  logic [1:0]            req_kind,
  input  logic [15:0]           req_sel,
  input  logic [31:0]           req_desc,
  output logic [AW-1:0]         mem_addr,
  output logic                  mem_we,
  output logic [31:0]           mem_wdata,
  input  logic [31:0]           mem_rdata,
  output logic [NDYN*32-1:0]    ctx_dyn,
  output logic [NSTAT*32-1:0]   ctx_stat,
  output logic [15:0]           cur_task,
  output logic                  busy,
  output logic                  done,
  output logic                  fault,
  output logic                  trap
);
  localparam int LAST = NDYN + NSTAT;
  localparam int CW = $clog2(LAST + 1);
  localparam int DIW = $clog2(NDYN);
  localparam int SIW = $clog2(NSTAT);
  localparam logic [1:0] K_CALL = 2'd1, K_RET = 2'd2, K_BAD = 2'd3;
  localparam logic [1:0] T_REC = 2'b01, T_GATE = 2'b10;

  typedef enum logic [3:0] {S_IDLE, S_GDA, S_GDD, S_LKA, S_LKD, S_SAVE, S_LINK, S_LOAD, S_CHK} st_t;

  st_t state;
  logic [CW-1:0] cnt;
  logic [1:0] kind;
  logic [15:0] nsel, cur_sel;
  logic [AW-1:0] nbase, cur_base;
  logic [NDYN-1:0][31:0] dyn_q;
  logic [NSTAT-1:0][31:0] stat_q;
  logic fault_q, trap_q;

  logic [CW-1:0] lidx;
  logic [SIW-1:0] sidx;
  assign lidx = cnt - CW'(1);
  assign sidx = SIW'(lidx - CW'(NDYN));

  assign ctx_dyn  = dyn_q;
  assign ctx_stat = stat_q;
  assign cur_task = cur_sel;
  assign busy  = state != S_IDLE;
  assign done  = state == S_CHK;
  assign fault = fault_q;
  assign trap  = trap_q;
  assign mem_we = state == S_SAVE || state == S_LINK;

  always_comb begin
    mem_addr  = '0;
    mem_wdata = '0;
    case (state)
      S_GDA:  mem_addr = DESC_BASE + AW'(nsel);
      S_LKA:  mem_addr = cur_base;
      S_SAVE: begin
        mem_addr  = cur_base + AW'(cnt) + AW'(1);
        mem_wdata = dyn_q[cnt[DIW-1:0]];
      end
      S_LINK: begin
        mem_addr  = nbase;
        mem_wdata = {16'b0, cur_sel};
      end
      S_LOAD: mem_addr = nbase + AW'(cnt) + AW'(1);
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= S_IDLE;
      cnt <= '0;
      kind <= '0;
      nsel <= '0;
      nbase <= '0;
      cur_sel <= '0;
      cur_base <= '0;
      dyn_q <= '0;
      stat_q <= '0;
      fault_q <= 1'b0;
      trap_q <= 1'b0;
    end else begin
      fault_q <= 1'b0;
      trap_q <= state == S_CHK && stat_q[NSTAT-1][0];
      case (state)
        S_IDLE: if (req) begin
          kind <= req_kind;
          cnt <= '0;
          if (req_kind == K_RET) state <= S_LKA;
          else if (req_kind == K_BAD) fault_q <= 1'b1;
          else if (req_desc[31:30] == T_REC) begin
            nbase <= req_desc[AW-1:0];
            nsel <= req_sel;
            state <= S_SAVE;
          end else if (req_desc[31:30] == T_GATE) begin
            nsel <= req_desc[15:0];
            state <= S_GDA;
          end else fault_q <= 1'b1;
        end
        S_GDA: state <= S_GDD;
        S_GDD: if (mem_rdata[31:30] == T_REC) begin
          nbase <= mem_rdata[AW-1:0];
          state <= S_SAVE;
        end else begin
          fault_q <= 1'b1;
          state <= S_IDLE;
        end
        S_LKA: state <= S_LKD;
        S_LKD: if (mem_rdata[15:0] == 16'd0) begin
          fault_q <= 1'b1;
          state <= S_IDLE;
        end else begin
          nsel <= mem_rdata[15:0];
          state <= S_GDA;
        end
        S_SAVE: if (cnt == CW'(NDYN - 1)) begin
          cnt <= '0;
          state <= (kind == K_CALL) ? S_LINK : S_LOAD;
        end else cnt <= cnt + CW'(1);
        S_LINK: state <= S_LOAD;
        S_LOAD: begin
          if (cnt != '0) begin
            if (lidx < CW'(NDYN)) dyn_q[lidx[DIW-1:0]] <= mem_rdata;
            else stat_q[sidx] <= mem_rdata;
          end
          if (cnt == CW'(LAST)) begin
            cnt <= '0;
            cur_sel <= nsel;
            cur_base <= nbase;
            state <= S_CHK;
          end else cnt <= cnt + CW'(1);
        end
        S_CHK: state <= S_IDLE;
        default: state <= S_IDLE;
      endcase
    end
  end

  assert_done_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_fault_keeps_state_R7: assert property (@(posedge clk) disable iff (!rst_n)
    fault |-> ($stable(ctx_dyn) && $stable(ctx_stat) && $stable(cur_task) && !busy));

  assert_no_static_write_R4: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> ((mem_addr == nbase && kind == K_CALL) ||
                ((mem_addr - cur_base) >= AW'(1) && (mem_addr - cur_base) <= AW'(NDYN))));

  assert_save_stride_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_SAVE && cnt != '0) |-> (mem_we && mem_addr == $past(mem_addr) + AW'(1)));

  assert_trap_after_done_R9: assert property (@(posedge clk) disable iff (!rst_n)
    trap |-> $past(done));

  assert_task_on_done_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(cur_task) |-> done);
endmodule

// File: tb/task_switch_seq_test.sv
`timescale 1ns/1ps
module task_switch_seq_test;
  localparam logic [15:0] DB = 16'h0800;
  logic clk = 0, rst_n = 0, req = 0;
  logic [1:0] req_kind = 0;
  logic [15:0] req_sel = 0;
  logic [31:0] req_desc = 0;
  logic [15:0] mem_addr;
  logic mem_we;
  logic [31:0] mem_wdata, mem_rdata;
  logic [511:0] ctx_dyn;
  logic [191:0] ctx_stat;
  logic [15:0] cur_task;
  logic busy, done, fault, trap;

  task_switch_seq uut (.clk(clk), .rst_n(rst_n), .req(req), .req_kind(req_kind), .req_sel(req_sel),
    .req_desc(req_desc), .mem_addr(mem_addr), .mem_we(mem_we), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata), .ctx_dyn(ctx_dyn), .ctx_stat(ctx_stat), .cur_task(cur_task),
    .busy(busy), .done(done), .fault(fault), .trap(trap));

  always #10 clk = ~clk;

  logic [31:0] mem [0:4095];
  logic [31:0] em [0:4095];
  logic [31:0] edyn [0:15];
  logic [31:0] estat [0:5];
  logic [15:0] esel, ebase;
  int checks = 0, fails = 0, wr_cnt = 0;
  int last_addr = -1, nonseq = 0;

  always @(posedge clk) begin
    if (mem_we) mem[mem_addr[11:0]] <= mem_wdata;
    mem_rdata <= mem[mem_addr[11:0]];
  end

  always @(negedge clk) if (mem_we) begin
    if (wr_cnt > 0 && wr_cnt < 16 && int'(mem_addr) != last_addr + 1) nonseq++;
    last_addr = int'(mem_addr);
    wr_cnt++;
  end

  task automatic chk(input bit ok, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", what, act, exp);
    end
  endtask

  function automatic int live_mismatch();
    int m = 0;
    for (int i = 0; i < 16; i++) if (ctx_dyn[i*32 +: 32] !== edyn[i]) m++;
    for (int j = 0; j < 6; j++) if (ctx_stat[j*32 +: 32] !== estat[j]) m++;
    return m;
  endfunction

  function automatic int mem_mismatch();
    int m = 0;
    for (int a = 0; a < 4096; a++) if (mem[a] !== em[a]) m++;
    return m;
  endfunction

  task automatic run_op(input logic [1:0] k, input logic [15:0] s, input logic [31:0] d, input bit poke, input string tag);
    bit ok = 1;
    logic [15:0] nsel = 0, nbase = 0;
    logic [31:0] t;
    bit etrap;
    int n;
    if (k == 2'd3) ok = 0;
    else if (k == 2'd2) begin
      nsel = em[ebase][15:0];
      if (nsel == 0) ok = 0;
      else begin t = em[DB + nsel]; if (t[31:30] != 2'b01) ok = 0; else nbase = t[15:0]; end
    end else if (d[31:30] == 2'b01) begin nsel = s; nbase = d[15:0]; end
    else if (d[31:30] == 2'b10) begin
      nsel = d[15:0]; t = em[DB + nsel];
      if (t[31:30] != 2'b01) ok = 0; else nbase = t[15:0];
    end else ok = 0;
    if (ok) begin
      for (int i = 0; i < 16; i++) em[ebase + 16'(i) + 1] = edyn[i];
      if (k == 2'd1) em[nbase] = {16'b0, esel};
      for (int i = 0; i < 16; i++) edyn[i] = em[nbase + 16'(i) + 1];
      for (int j = 0; j < 6; j++) estat[j] = em[nbase + 16'(j) + 17];
      esel = nsel; ebase = nbase;
    end
    etrap = ok && estat[5][0];
    wr_cnt = 0; nonseq = 0;
    @(negedge clk); req = 1; req_kind = k; req_sel = s; req_desc = d;
    @(negedge clk); req = 0;
    n = 0;
    while (!done && !fault && n < 100) begin
      if (poke && n == 3) begin req = 1; req_kind = 2'd3; req_desc = 32'h0; end
      else req = 0;
      @(negedge clk); n++;
    end
    req = 0;
    chk(fault == !ok, {tag, " R7 fault outcome"}, {31'b0, fault}, {31'b0, !ok});
    chk(cur_task == esel, {tag, " R2 R3 R6 cur_task"}, {16'b0, cur_task}, {16'b0, esel});
    chk(live_mismatch() == 0, {tag, " R2 live registers"}, live_mismatch(), 0);
    chk(wr_cnt == (!ok ? 0 : (k == 2'd1 ? 17 : 16)), {tag, " R11 write count"}, wr_cnt, 0);
    chk(nonseq == 0, {tag, " R11 ascending save"}, nonseq, 0);
    if (ok) begin
      chk(done && busy, {tag, " R8 done while busy"}, {30'b0, done, busy}, 32'h3);
      @(negedge clk);
      chk(!done && !busy, {tag, " R8 done one cycle"}, {30'b0, done, busy}, 0);
      chk(trap == etrap, {tag, " R9 trap pulse"}, {31'b0, trap}, {31'b0, etrap});
      @(negedge clk);
      chk(!trap, {tag, " R9 trap one cycle"}, {31'b0, trap}, 0);
    end else begin
      chk(!busy, {tag, " R7 idle after fault"}, {31'b0, busy}, 0);
      @(negedge clk);
      chk(!fault, {tag, " R7 fault one cycle"}, {31'b0, fault}, 0);
    end
    chk(mem_mismatch() == 0, {tag, " R4 R5 memory image"}, mem_mismatch(), 0);
  endtask

  function automatic logic [31:0] rec_desc(input int k);
    return {2'b01, 14'b0, 16'(64 * k)};
  endfunction
  function automatic logic [31:0] gate_desc(input int k);
    return {2'b10, 14'b0, 16'(k)};
  endfunction

  initial begin
    void'($urandom(32'd1234));
    for (int a = 0; a < 4096; a++) em[a] = 32'h0;
    for (int k = 1; k <= 8; k++) begin
      em[64 * k] = ($urandom % 3 == 0) ? 32'h0 : 32'(1 + $urandom % 8);
      for (int w = 1; w < 23; w++) em[64 * k + w] = $urandom;
      em[64 * k + 22][0] = ($urandom % 4 == 0);
      em[DB + 16'(k)] = rec_desc(k);
    end
    em[DB] = rec_desc(0);
    em[DB + 16'd9] = 32'hC000_0040;
    em[64 * 3 + 22][0] = 1'b1;
    for (int a = 0; a < 4096; a++) mem[a] = em[a];
    for (int i = 0; i < 16; i++) edyn[i] = 0;
    for (int j = 0; j < 6; j++) estat[j] = 0;
    esel = 0; ebase = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(!busy && !done && !fault && !trap, "R1 reset outputs idle", {28'b0, busy, done, fault, trap}, 0);
    chk(cur_task == 0, "R1 reset cur_task", {16'b0, cur_task}, 0);
    chk(ctx_dyn == '0 && ctx_stat == '0, "R1 reset live registers", ctx_dyn[31:0], 0);

    run_op(2'd2, 0, 0, 0, "R6 return null link");
    run_op(2'd3, 0, rec_desc(1), 0, "R7 kind 3");
    run_op(2'd0, 1, 32'h0000_0040, 0, "R7 type 00");
    run_op(2'd1, 1, 32'hC000_0040, 0, "R7 type 11");
    run_op(2'd0, 0, gate_desc(9), 0, "R3 gate to non-record");
    run_op(2'd0, 1, rec_desc(1), 0, "R2 jump direct");
    run_op(2'd1, 0, gate_desc(3), 1, "R3 R10 call via gate");
    run_op(2'd2, 0, 0, 0, "R6 return to caller");
    run_op(2'd0, 1, rec_desc(1), 0, "R2 jump to self");
    run_op(2'd1, 2, rec_desc(2), 0, "R5 call direct");
    run_op(2'd1, 4, rec_desc(4), 0, "R5 nested call");
    run_op(2'd2, 0, 0, 0, "R6 unwind one");
    run_op(2'd2, 0, 0, 0, "R6 unwind two");

    for (int it = 0; it < 60; it++) begin
      int r = $urandom % 10;
      int k = 1 + $urandom % 8;
      case (r)
        0, 1, 2: run_op(2'd0, 16'(k), rec_desc(k), it % 4 == 0, "R2 random jump");
        3, 4:    run_op(2'd0, 0, gate_desc(k), it % 4 == 1, "R3 random gate jump");
        5:       run_op(2'd1, 16'(k), rec_desc(k), 0, "R5 random call");
        6:       run_op(2'd1, 0, gate_desc(k), 0, "R5 random gate call");
        7, 8:    run_op(2'd2, 0, 0, 0, "R6 random return");
        default: run_op(2'($urandom % 2), 16'(k), {2'b11, 30'h40}, 0, "R7 random bad");
      endcase
    end
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #(20 * 150000);
    fails++;
    $display("FAIL watchdog expired actual=hung expected=finish");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule